// File: doc/BRIEF.md
# Trace Event Filter and Trigger Matcher

This block watches a stream of bus transaction events and decides, one event at a time, whether each event should be captured into a trace store and whether it fires either of two trigger units. Every event presents a 6-bit command type, a 5-bit source index, a 5-bit destination index and a 64-bit address, qualified by a valid strobe.

There are three identical match units: the capture filter (unit 0) and triggers 0 and 1 (units 1 and 2). Each unit holds five registers: a command mask, a source mask, a destination mask, an address compare value and an address mask. Software programs them through a write-only register port. A unit matches when all four checks pass for the same event: the command bit is set, the source bit is set, the destination bit is set, and the address agrees with the compare value on every bit the address mask selects. The capture-enable output and the two trigger outputs are registered and appear one cycle after the event. Event storage, timestamps and arming logic that consumes the trigger pulses sit outside this block.

Top module: `trace_event_matcher`

## Requirements
- R1: After reset, all outputs are low and every mask and compare register is zero. No event matches until software programs the units.
- R2: An event passes the command check of a unit only when bit [type] of that unit's 64-bit command mask is set.
- R3: Writes to a command mask force bits 6, 7, 10 through 14, 27, 56, 57, 60 and 61 to zero, so events with those type codes never match, even after an all-ones write.
- R4: The source mask is 20 bits wide, indexed by the source index. Written bits above 19 are dropped, and source indices 20 to 31 never match.
- R5: The destination check passes only when bit [destination index] of the 32-bit destination mask is set.
- R6: The address check passes when ((address XOR compare) AND mask) is zero. An all-zero address mask makes it always pass.
- R7: A unit reports a match only when the command, source, destination and address checks all pass for the same event.
- R8: Register map on the 8-bit byte address. Bits [7:6] select the unit: 0 is the filter, 1 is trigger 0 (base 0x40), 2 is trigger 1 (base 0x80, 64 bytes above trigger 0). Bits [5:3] select the register: 0 command mask, 1 source mask, 2 destination mask, 3 address compare, 4 address mask. Writes with nonzero bits [2:0], with unit 3, or with register 5 to 7 change nothing.
- R9: capture_en reflects the filter unit and trig_hit[0] and trig_hit[1] reflect the two triggers. Each output is registered, rises in the cycle after the event, and is low after any cycle in which ev_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte address |
| cfg_wdata | input | 64 | Register write data |
| ev_valid | input | 1 | Event qualifier |
| ev_cmd | input | 6 | Event command type |
| ev_src | input | 5 | Event source index |
| ev_dst | input | 5 | Event destination index |
| ev_addr | input | 64 | Event address |
| capture_en | output | 1 | Filter match pulse, one cycle after the event |
| trig_hit | output | 2 | Trigger 0 and trigger 1 match pulses, one cycle after the event |

## Verification
The assertions assume that reset is synchronous and held for at least one clock edge. They also assume that the event fields carry known values whenever ev_valid is high, because each one relates a match pulse back to the event and configuration seen one cycle earlier. The stimulus changes every input only on the falling clock edge and keeps ev_valid low in every cycle that writes a register. Event fields therefore never arrive in the same cycle as a configuration change, and each expected result depends on only one configuration.

// File: rtl/trc_match_pkg.sv
package trc_match_pkg;
    localparam int CMD_IW  = 6;
    localparam int CMD_N   = 1 << CMD_IW;
    localparam int SRC_N   = 20;
    localparam int SRC_IW  = 5;
    localparam int SRC_SPAN = 1 << SRC_IW;
    localparam int DST_N   = 32;
    localparam int DST_IW  = 5;
    localparam int DST_SPAN = 1 << DST_IW;
    localparam int ADDR_W  = 64;
    localparam int DATA_W  = 64;
    localparam int UNITS   = 3;
    localparam int CFG_AW  = 8;
    localparam int UNIT_LG = 6;                // 64-byte span per unit
    localparam int WORD_LG = 3;                // 8-byte registers
    localparam int UNIT_IW = CFG_AW - UNIT_LG;
    localparam int REG_IW  = UNIT_LG - WORD_LG;

    localparam logic [REG_IW-1:0] REG_CMD  = REG_IW'(0);
    localparam logic [REG_IW-1:0] REG_SRC  = REG_IW'(1);
    localparam logic [REG_IW-1:0] REG_DST  = REG_IW'(2);
    localparam logic [REG_IW-1:0] REG_ACMP = REG_IW'(3);
    localparam logic [REG_IW-1:0] REG_AMSK = REG_IW'(4);

    // Command type codes that can never be enabled
    localparam logic [CMD_N-1:0] CMD_RSVD =
        (CMD_N'(3) << 6) | (CMD_N'(5'h1f) << 10) | (CMD_N'(1) << 27) |
        (CMD_N'(3) << 56) | (CMD_N'(3) << 60);

    typedef struct packed {
        logic [CMD_N-1:0]  cmd;
        logic [SRC_N-1:0]  src;
        logic [DST_N-1:0]  dst;
        logic [ADDR_W-1:0] acmp;
        logic [ADDR_W-1:0] amsk;
    } unit_cfg_t;
endpackage

// File: rtl/trc_match_cfg.sv
module trc_match_cfg
    import trc_match_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic [CFG_AW-1:0]       addr,
    input  logic [DATA_W-1:0]       wdata,
    output unit_cfg_t [UNITS-1:0]   cfg_o
);
    typedef struct packed {
        unit_cfg_t [UNITS-1:0] unit;
    } cfg_state_t;

    localparam logic [CFG_AW-1:0] T0_CMD_ADDR = CFG_AW'(1 << UNIT_LG);

    cfg_state_t         st_d, st_q;
    logic [UNIT_IW-1:0] sel_unit;
    logic [REG_IW-1:0]  sel_reg;
    logic               aligned;

    always_comb begin
        sel_unit = addr[CFG_AW-1:UNIT_LG];
        sel_reg  = addr[UNIT_LG-1:WORD_LG];
        aligned  = (addr[WORD_LG-1:0] == '0);
        st_d     = st_q;
        for (int i = 0; i < UNITS; i++) begin
            if (we && aligned && (sel_unit == UNIT_IW'(i))) begin
                case (sel_reg)
                    REG_CMD:  st_d.unit[i].cmd  = wdata[CMD_N-1:0] & ~CMD_RSVD;
                    REG_SRC:  st_d.unit[i].src  = wdata[SRC_N-1:0];
                    REG_DST:  st_d.unit[i].dst  = wdata[DST_N-1:0];
                    REG_ACMP: st_d.unit[i].acmp = wdata[ADDR_W-1:0];
                    REG_AMSK: st_d.unit[i].amsk = wdata[ADDR_W-1:0];
                    default:  ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign cfg_o = st_q.unit;

    AST_CMD_WRITE_MASKED: assert property (@(posedge clk) disable iff (rst)
        (we && addr == T0_CMD_ADDR) |=> (cfg_o[1].cmd == ($past(wdata[CMD_N-1:0]) & ~CMD_RSVD))); // R3
    AST_STRAY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (we && ((addr[WORD_LG-1:0] != '0) || (addr[CFG_AW-1:UNIT_LG] >= UNIT_IW'(UNITS))))
        |=> $stable(cfg_o)); // R8
endmodule

// File: rtl/trc_match_unit.sv
module trc_match_unit
    import trc_match_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  unit_cfg_t         cfg_i,
    input  logic              ev_valid,
    input  logic [CMD_IW-1:0] ev_cmd,
    input  logic [SRC_IW-1:0] ev_src,
    input  logic [DST_IW-1:0] ev_dst,
    input  logic [ADDR_W-1:0] ev_addr,
    output logic              hit_o
);
    typedef struct packed {
        logic hit;
    } unit_state_t;

    unit_state_t         st_d, st_q;
    logic [SRC_SPAN-1:0] src_wide;
    logic [DST_SPAN-1:0] dst_wide;
    logic                cmd_ok, src_ok, dst_ok, addr_ok;

    always_comb begin
        src_wide = SRC_SPAN'(cfg_i.src);
        dst_wide = DST_SPAN'(cfg_i.dst);
        cmd_ok   = cfg_i.cmd[ev_cmd];
        src_ok   = src_wide[ev_src];
        dst_ok   = dst_wide[ev_dst];
        addr_ok  = (((ev_addr ^ cfg_i.acmp) & cfg_i.amsk) == '0);
        st_d     = st_q;
        st_d.hit = ev_valid && cmd_ok && src_ok && dst_ok && addr_ok;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign hit_o = st_q.hit;

    AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        hit_o |-> $past(ev_valid)); // R9
    AST_HIT_CMD_ENABLED: assert property (@(posedge clk) disable iff (rst)
        hit_o |-> ($past(cfg_i.cmd) >> $past(ev_cmd)) & CMD_N'(1)) ; // R2
    AST_NO_RSVD_HIT: assert property (@(posedge clk) disable iff (rst)
        hit_o |-> !CMD_RSVD[$past(ev_cmd)]); // R3
    AST_SRC_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        hit_o |-> ($past(ev_src) < SRC_IW'(SRC_N))); // R4
    AST_ADDR_AGREES: assert property (@(posedge clk) disable iff (rst)
        hit_o |-> ((($past(ev_addr) ^ $past(cfg_i.acmp)) & $past(cfg_i.amsk)) == '0)); // R6
endmodule

// File: rtl/trace_event_matcher.sv
module trace_event_matcher
    import trc_match_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              ev_valid,
    input  logic [CMD_IW-1:0] ev_cmd,
    input  logic [SRC_IW-1:0] ev_src,
    input  logic [DST_IW-1:0] ev_dst,
    input  logic [ADDR_W-1:0] ev_addr,
    output logic              capture_en,
    output logic [UNITS-2:0]  trig_hit
);
    unit_cfg_t [UNITS-1:0] cfg_w;
    logic [UNITS-1:0]      hits;

    trc_match_cfg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .cfg_o (cfg_w)
    );

    for (genvar g = 0; g < UNITS; g++) begin : g_unit
        trc_match_unit u_match (
            .clk      (clk),
            .rst      (rst),
            .cfg_i    (cfg_w[g]),
            .ev_valid (ev_valid),
            .ev_cmd   (ev_cmd),
            .ev_src   (ev_src),
            .ev_dst   (ev_dst),
            .ev_addr  (ev_addr),
            .hit_o    (hits[g])
        );
    end

    assign capture_en = hits[0];
    assign trig_hit   = hits[UNITS-1:1];

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !ev_valid |=> (hits == '0)); // R9
endmodule

// File: tb/trace_event_matcher_tb_top.sv
`timescale 1ns/1ps
module trace_event_matcher_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [63:0] cfg_wdata = '0;
    logic        ev_valid = 1'b0;
    logic [5:0]  ev_cmd = '0;
    logic [4:0]  ev_src = '0;
    logic [4:0]  ev_dst = '0;
    logic [63:0] ev_addr = '0;
    logic        capture_en;
    logic [1:0]  trig_hit;

    always #4 clk = ~clk;

    trace_event_matcher dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .ev_valid(ev_valid), .ev_cmd(ev_cmd),
        .ev_src(ev_src), .ev_dst(ev_dst), .ev_addr(ev_addr),
        .capture_en(capture_en), .trig_hit(trig_hit)
    );

    localparam logic [63:0] RSVD_CODES = 64'h3300_0000_0800_7CC0;

    typedef struct {
        logic [2:0] exp;
        string      tag;
    } sb_item_t;

    sb_item_t    sb_q[$];
    sb_item_t    item;
    int          checks = 0;
    int          errors = 0;
    logic [63:0] m_cmd  [3];
    logic [31:0] m_src  [3];
    logic [31:0] m_dst  [3];
    logic [63:0] m_acmp [3];
    logic [63:0] m_amsk [3];

    function automatic logic model_hit(int u, logic v, logic [5:0] c,
                                       logic [4:0] s, logic [4:0] d, logic [63:0] a);
        if (!v) return 1'b0;
        if (!m_cmd[u][c]) return 1'b0;
        if (s >= 5'd20) return 1'b0;
        if (!m_src[u][s]) return 1'b0;
        if (!m_dst[u][d]) return 1'b0;
        return (((a ^ m_acmp[u]) & m_amsk[u]) == 64'd0);
    endfunction

    task automatic push(input logic [2:0] e, input string t);
        sb_item_t it;
        it.exp = e;
        it.tag = t;
        sb_q.push_back(it);
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [63:0] d);
        int u;
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d; ev_valid = 1'b0;
        push(3'b000, "R9 quiet while writing");
        if (a[2:0] == 3'd0 && a[7:6] < 2'd3) begin
            u = int'(a[7:6]);
            case (a[5:3])
                3'd0: m_cmd[u]  = d & ~RSVD_CODES;
                3'd1: m_src[u]  = {12'h000, d[19:0]};
                3'd2: m_dst[u]  = d[31:0];
                3'd3: m_acmp[u] = d;
                3'd4: m_amsk[u] = d;
                default: ;
            endcase
        end
        @(negedge clk);
        cfg_we = 1'b0;
        push(3'b000, "R9 quiet after write");
    endtask

    task automatic send_ev(input logic v, input logic [5:0] c, input logic [4:0] s,
                           input logic [4:0] d, input logic [63:0] a, input string t);
        @(negedge clk);
        ev_valid = v; ev_cmd = c; ev_src = s; ev_dst = d; ev_addr = a;
        push({model_hit(2, v, c, s, d, a), model_hit(1, v, c, s, d, a),
              model_hit(0, v, c, s, d, a)}, t);
    endtask

    always @(posedge clk) begin
        #2;
        if (sb_q.size() > 0) begin
            item = sb_q.pop_front();
            checks++;
            if ({trig_hit, capture_en} !== item.exp) begin
                errors++;
                $display("FAIL %s: got %b expected %b", item.tag, {trig_hit, capture_en}, item.exp);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 3; i++) begin
            m_cmd[i] = '0; m_src[i] = '0; m_dst[i] = '0; m_acmp[i] = '0; m_amsk[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        checks++;
        if ({trig_hit, capture_en} !== 3'b000) begin
            errors++;
            $display("FAIL R1 reset outputs: got %b expected 000", {trig_hit, capture_en});
        end
        // R1: nothing matches on unprogrammed units
        send_ev(1'b1, 6'd3, 5'd5, 5'd9, 64'h0, "R1 unprogrammed");
        send_ev(1'b1, 6'd0, 5'd0, 5'd0, 64'h0, "R1 unprogrammed zero event");

        // filter: type 3, source 5, destination 9, address mask zero
        cfg_write(8'h00, 64'h8);
        cfg_write(8'h08, 64'h20);
        cfg_write(8'h10, 64'h200);
        send_ev(1'b1, 6'd3, 5'd5, 5'd9, 64'hDEAD_BEEF_0000_1234, "R6 zero mask passes / R7 all pass");
        send_ev(1'b1, 6'd4, 5'd5, 5'd9, 64'h0, "R2 command bit clear");
        send_ev(1'b1, 6'd3, 5'd6, 5'd9, 64'h0, "R4 source bit clear");
        send_ev(1'b1, 6'd3, 5'd5, 5'd10, 64'h0, "R5 destination bit clear");
        send_ev(1'b0, 6'd3, 5'd5, 5'd9, 64'h0, "R9 valid low suppressed");
        send_ev(1'b1, 6'd3, 5'd5, 5'd9, 64'h1, "R9 back to back event");

        // R3: reserved command types
        cfg_write(8'h00, 64'hFFFF_FFFF_FFFF_FFFF);
        send_ev(1'b1, 6'd6, 5'd5, 5'd9, 64'h0, "R3 reserved type 6");
        send_ev(1'b1, 6'd12, 5'd5, 5'd9, 64'h0, "R3 reserved type 12");
        send_ev(1'b1, 6'd27, 5'd5, 5'd9, 64'h0, "R3 reserved type 27");
        send_ev(1'b1, 6'd61, 5'd5, 5'd9, 64'h0, "R3 reserved type 61");
        send_ev(1'b1, 6'd63, 5'd5, 5'd9, 64'h0, "R3 type 63 allowed");
        send_ev(1'b1, 6'd8, 5'd5, 5'd9, 64'h0, "R2 type 8 allowed");

        // R4: source bits above 19
        cfg_write(8'h08, 64'hFFFF_FFFF_FFFF_FFFF);
        send_ev(1'b1, 6'd3, 5'd19, 5'd9, 64'h0, "R4 source 19");
        send_ev(1'b1, 6'd3, 5'd20, 5'd9, 64'h0, "R4 source 20");
        send_ev(1'b1, 6'd3, 5'd31, 5'd9, 64'h0, "R4 source 31");

        // R6: masked address compare
        cfg_write(8'h18, 64'hABCD_0000_0000_0000);
        cfg_write(8'h20, 64'hFFFF_0000_0000_0000);
        send_ev(1'b1, 6'd3, 5'd5, 5'd9, 64'hABCD_1111_2222_3333, "R6 masked equal");
        send_ev(1'b1, 6'd3, 5'd5, 5'd9, 64'hABCE_1111_2222_3333, "R6 masked differ");
        send_ev(1'b1, 6'd3, 5'd5, 5'd31, 64'hABCD_0000_0000_0000, "R7 destination fails alone");

        // R8: triggers at 0x40 and 0x80
        cfg_write(8'h40, 64'h1_0000);
        cfg_write(8'h48, 64'h1);
        cfg_write(8'h50, 64'h8000_0000);
        cfg_write(8'h58, 64'h40);
        cfg_write(8'h60, 64'hFF);
        cfg_write(8'h80, 64'h1_0000);
        cfg_write(8'h88, 64'h2);
        cfg_write(8'h90, 64'h8000_0000);
        send_ev(1'b1, 6'd16, 5'd0, 5'd31, 64'h40, "R8 trigger 0 only");
        send_ev(1'b1, 6'd16, 5'd1, 5'd31, 64'h77, "R8 trigger 1 only");
        send_ev(1'b1, 6'd16, 5'd0, 5'd31, 64'h41, "R7 trigger 0 address fails");
        cfg_write(8'h10, 64'h8000_0200);
        send_ev(1'b1, 6'd16, 5'd0, 5'd31, 64'hABCD_0000_0000_0040, "R8 filter and trigger 0");

        // R8: stray writes change nothing
        cfg_write(8'hC0, 64'h0);
        cfg_write(8'h28, 64'h0);
        cfg_write(8'h04, 64'h0);
        cfg_write(8'h44, 64'h0);
        send_ev(1'b1, 6'd16, 5'd0, 5'd31, 64'hABCD_0000_0000_0040, "R8 stray writes ignored");
        send_ev(1'b1, 6'd16, 5'd1, 5'd31, 64'hABCD_0000_0000_0040, "R8 filter and trigger 1");
        send_ev(1'b0, 6'd16, 5'd1, 5'd31, 64'hABCD_0000_0000_0040, "R9 valid low all units");

        @(negedge clk);
        ev_valid = 1'b0;
        push(3'b000, "R9 final idle");
        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule